// File: doc/BRIEF.md
# Transmit Completion Queue Writer

This block records finished transmissions in a circular completion queue that lives in host memory. Whenever a transmit data transfer ends, the block receives the descriptor index and the byte length of that transfer. It builds a 32-byte completion record and issues one DMA write that places the record in the next free slot of the queue.

The DMA engine returns acknowledgements in issue order. Each acknowledgement is matched against the committed head pointer. A matching acknowledgement advances that pointer and raises one request toward the event queue. The request has type transmit-completion and source 0.

Software programs the ring base address and the log2 of the ring size, and it reports the consumer (tail) pointer. The block stalls new completions when the ring has no free slot. It also stalls acknowledgements while an earlier event request has not yet been taken.

Top module: `txcpl_writer`

## Requirements
- R1: After reset, wrValid and evtValid are low, headOut is 0, and reqReady is high when cfgTail is 0.
- R2: The record on wrData is 256 bits wide, with byte 0 in bits 7:0. The index sits in bytes 2..3 (bits 31:16) and the length in bytes 4..5 (bits 47:32), both little-endian. Every other bit is zero, so the queue number, timestamp, checksum, hash and reserved fields are all zero.
- R3: wrAddr equals cfgBase plus 32 times the slot number, where the slot number is the speculative head AND (2^cfgSizeLog − 1). The slot therefore wraps to 0 after the last entry.
- R4: A request accepted at a clock edge shows up as wrValid from the next cycle. wrTag carries the speculative head at acceptance, and the speculative head then increments by one. wrValid, wrAddr, wrData and wrTag stay unchanged until wrReady is sampled high.
- R5: reqReady is low while a write is waiting for wrReady, so only one write is held at a time.
- R6: reqReady is low whenever (speculative head − cfgTail) mod 2^16 ≥ 2^cfgSizeLog.
- R7: An acknowledgement with ackTag equal to the committed head, taken while at least one write is outstanding, increments headOut and raises evtValid in the next cycle. The request carries evtType 16'h0000 and evtSource 16'h0000.
- R8: Some acknowledgements are ignored: those whose tag differs from the committed head, and those that arrive when no write is outstanding. An ignored acknowledgement leaves headOut unchanged and raises no event.
- R9: evtValid stays high until evtReady is sampled high. At most one event request is held. ackReady is low exactly when an event is pending and evtReady is low.
- R10: headOut shows the committed head, which advances only on accepted, matching acknowledgements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgBase | input | 64 | Ring base address in host memory |
| cfgSizeLog | input | 5 | log2 of the ring entry count (0..16) |
| cfgTail | input | 16 | Consumer pointer written by software |
| reqValid | input | 1 | Completion request present |
| reqReady | output | 1 | Completion request accepted |
| reqIndex | input | 16 | Descriptor index of the finished transfer |
| reqLen | input | 16 | Byte length of the finished transfer (up to 2048) |
| wrValid | output | 1 | DMA write request valid |
| wrReady | input | 1 | DMA engine takes the write |
| wrAddr | output | 64 | Host address of the slot |
| wrData | output | 256 | Completion record, byte 0 in the low bits |
| wrTag | output | 16 | Tag of the write (speculative head) |
| ackValid | input | 1 | Write acknowledgement present |
| ackReady | output | 1 | Acknowledgement accepted |
| ackTag | input | 16 | Tag of the acknowledged write |
| evtValid | output | 1 | Event request valid |
| evtReady | input | 1 | Event queue takes the request |
| evtType | output | 16 | Event type, 0 for transmit completion |
| evtSource | output | 16 | Event source, always 0 |
| headOut | output | 16 | Committed head pointer |

## Verification
Every result is due one clock edge after the stimulus that causes it. A request taken at an edge puts its write on wrValid, wrAddr, wrData and wrTag in the following cycle. A matching acknowledgement taken at an edge moves headOut and raises evtValid in the following cycle. reqReady and ackReady are combinational in the current state and in cfgTail and evtReady, so they are due in the same cycle. The bench drives inputs two nanoseconds after each rising edge and advances its reference model at the rising edge. It compares every output at the falling edge, when both the model and the design have settled for that cycle.

// File: rtl/txcpl_pkg.sv
package txcpl_pkg;

  localparam int REC_BITS = 256;
  localparam logic [15:0] EVT_TYPE_TX_DONE = 16'h0000;
  localparam logic [15:0] EVT_SRC_PORT0 = 16'h0000;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch a new record and bump the speculative head
    logic commit;   // bump the committed head
  } txcpl_strobe_t;

  // little-endian record: bytes 2..3 index, bytes 4..5 length, rest zero
  function automatic logic [REC_BITS-1:0] packRecord(input logic [15:0] idx,
                                                     input logic [15:0] len);
    logic [REC_BITS-1:0] rec;
    rec = '0;
    rec[31:16] = idx;
    rec[47:32] = len;
    return rec;
  endfunction

endpackage

// File: rtl/txcpl_ctrl.sv
module txcpl_ctrl
  import txcpl_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          reqValid,
  output logic          reqReady,
  output logic          wrValid,
  input  logic          wrReady,
  input  logic          ackValid,
  output logic          ackReady,
  output logic          evtValid,
  input  logic          evtReady,
  input  logic          ringFull,
  input  logic          tagMatch,
  output txcpl_strobe_t strobe
);

  logic wrBusy;
  logic evtPending;

  assign reqReady = !wrBusy && !ringFull;
  assign ackReady = !evtPending || evtReady;

  always_comb begin
    strobe.capture = reqValid && reqReady;
    strobe.commit  = ackValid && ackReady && tagMatch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrBusy <= 1'b0;
    end else if (strobe.capture) begin
      wrBusy <= 1'b1;
    end else if (wrReady) begin
      wrBusy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evtPending <= 1'b0;
    end else if (strobe.commit) begin
      evtPending <= 1'b1;
    end else if (evtReady) begin
      evtPending <= 1'b0;
    end
  end

  assign wrValid  = wrBusy;
  assign evtValid = evtPending;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    wrValid && !wrReady |=> wrValid) else $error("write dropped");  // R4
  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (rst)
    evtValid && !evtReady |=> evtValid) else $error("event dropped");  // R9
  AST_EVT_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
    strobe.commit |=> evtValid) else $error("no event after commit");  // R7
  AST_ONE_PENDING: assert property (@(posedge clk) disable iff (rst)
    ackValid && evtValid && !evtReady |-> !ackReady) else $error("second event accepted");  // R9

endmodule

// File: rtl/txcpl_datapath.sv
module txcpl_datapath
  import txcpl_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int PTR_W  = 16,
  parameter int LOG_W  = 5,
  parameter int REC_SHIFT = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  txcpl_strobe_t        strobe,
  input  logic [ADDR_W-1:0]    cfgBase,
  input  logic [LOG_W-1:0]     cfgSizeLog,
  input  logic [PTR_W-1:0]     cfgTail,
  input  logic [15:0]          reqIndex,
  input  logic [15:0]          reqLen,
  input  logic [PTR_W-1:0]     ackTag,
  output logic                 ringFull,
  output logic                 tagMatch,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [REC_BITS-1:0]  wrData,
  output logic [PTR_W-1:0]     wrTag,
  output logic [PTR_W-1:0]     headOut
);

  localparam int CNT_W = PTR_W + 1;

  logic [PTR_W-1:0] specHead;
  logic [PTR_W-1:0] commitHead;
  logic [CNT_W-1:0] ringSize;
  logic [PTR_W-1:0] slotMask;
  logic [PTR_W-1:0] fillLevel;
  logic [PTR_W-1:0] slotNum;

  always_comb begin
    ringSize  = CNT_W'(1) << cfgSizeLog;
    slotMask  = ringSize[PTR_W-1:0] - PTR_W'(1);
    fillLevel = specHead - cfgTail;
    ringFull  = {1'b0, fillLevel} >= ringSize;
    slotNum   = specHead & slotMask;
    tagMatch  = (ackTag == commitHead) && (commitHead != specHead);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      specHead <= '0;
      wrAddr   <= '0;
      wrData   <= '0;
      wrTag    <= '0;
    end else if (strobe.capture) begin
      wrAddr   <= cfgBase + (ADDR_W'(slotNum) << REC_SHIFT);
      wrData   <= packRecord(reqIndex, reqLen);
      wrTag    <= specHead;
      specHead <= specHead + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      commitHead <= '0;
    end else if (strobe.commit) begin
      commitHead <= commitHead + PTR_W'(1);
    end
  end

  assign headOut = commitHead;

  AST_TAG_IS_HEAD: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |=> wrTag == $past(specHead)) else $error("tag mismatch");  // R4
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (rst)
    !strobe.commit |=> $stable(headOut)) else $error("head moved without commit");  // R10

endmodule

// File: rtl/txcpl_writer.sv
module txcpl_writer
  import txcpl_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int PTR_W  = 16,
  parameter int LOG_W  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   cfgBase,
  input  logic [LOG_W-1:0]    cfgSizeLog,
  input  logic [PTR_W-1:0]    cfgTail,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [15:0]         reqIndex,
  input  logic [15:0]         reqLen,
  output logic                wrValid,
  input  logic                wrReady,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [REC_BITS-1:0] wrData,
  output logic [PTR_W-1:0]    wrTag,
  input  logic                ackValid,
  output logic                ackReady,
  input  logic [PTR_W-1:0]    ackTag,
  output logic                evtValid,
  input  logic                evtReady,
  output logic [15:0]         evtType,
  output logic [15:0]         evtSource,
  output logic [PTR_W-1:0]    headOut
);

  txcpl_strobe_t strobe;
  logic ringFull;
  logic tagMatch;

  txcpl_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .wrValid  (wrValid),
    .wrReady  (wrReady),
    .ackValid (ackValid),
    .ackReady (ackReady),
    .evtValid (evtValid),
    .evtReady (evtReady),
    .ringFull (ringFull),
    .tagMatch (tagMatch),
    .strobe   (strobe)
  );

  txcpl_datapath #(
    .ADDR_W (ADDR_W),
    .PTR_W  (PTR_W),
    .LOG_W  (LOG_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .cfgBase    (cfgBase),
    .cfgSizeLog (cfgSizeLog),
    .cfgTail    (cfgTail),
    .reqIndex   (reqIndex),
    .reqLen     (reqLen),
    .ackTag     (ackTag),
    .ringFull   (ringFull),
    .tagMatch   (tagMatch),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .wrTag      (wrTag),
    .headOut    (headOut)
  );

  assign evtType   = EVT_TYPE_TX_DONE;
  assign evtSource = EVT_SRC_PORT0;

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    ringFull |-> !reqReady) else $error("request taken while full");  // R6
  AST_WR_STABLE: assert property (@(posedge clk) disable iff (rst)
    wrValid && !wrReady |=> $stable(wrAddr) && $stable(wrData) && $stable(wrTag))
    else $error("write payload changed");  // R4
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    wrValid |-> !reqReady) else $error("request taken while write held");  // R5

endmodule

// File: tb/txcpl_writer_tb.sv
module txcpl_writer_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [63:0]  cfgBase = 64'h0000_0001_2340_0000;
  logic [4:0]   cfgSizeLog = 5'd2;
  logic [15:0]  cfgTail = 16'd0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [15:0]  reqIndex = '0;
  logic [15:0]  reqLen = '0;
  logic         wrValid;
  logic         wrReady = 1'b0;
  logic [63:0]  wrAddr;
  logic [255:0] wrData;
  logic [15:0]  wrTag;
  logic         ackValid = 1'b0;
  logic         ackReady;
  logic [15:0]  ackTag = '0;
  logic         evtValid;
  logic         evtReady = 1'b0;
  logic [15:0]  evtType;
  logic [15:0]  evtSource;
  logic [15:0]  headOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  txcpl_writer u_dut (
    .clk(clk), .rst(rst), .cfgBase(cfgBase), .cfgSizeLog(cfgSizeLog), .cfgTail(cfgTail),
    .reqValid(reqValid), .reqReady(reqReady), .reqIndex(reqIndex), .reqLen(reqLen),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData), .wrTag(wrTag),
    .ackValid(ackValid), .ackReady(ackReady), .ackTag(ackTag),
    .evtValid(evtValid), .evtReady(evtReady), .evtType(evtType), .evtSource(evtSource),
    .headOut(headOut)
  );

  // behavioural reference state
  int          mSpec = 0;
  int          mCommit = 0;
  bit          mWrBusy = 0;
  bit          mEvt = 0;
  logic [63:0] mAddr = '0;
  logic [15:0] mIdx = '0;
  logic [15:0] mLen = '0;
  int          mTag = 0;

  function automatic bit modelFull();
    int used;
    used = (mSpec - int'(cfgTail)) & 16'hFFFF;
    return used >= (1 << cfgSizeLog);
  endfunction

  task automatic check(string req, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mSpec = 0; mCommit = 0; mWrBusy = 0; mEvt = 0;
    end else begin
      bit rr, ar, doCommit, oldBusy;
      rr = !mWrBusy && !modelFull();
      ar = !mEvt || evtReady;
      doCommit = ackValid && ar && (int'(ackTag) == (mCommit & 16'hFFFF)) && (mCommit != mSpec);
      oldBusy = mWrBusy;
      if (reqValid && rr) begin
        mAddr = cfgBase + 64'(((mSpec & ((1 << cfgSizeLog) - 1)) * 32));
        mIdx = reqIndex;
        mLen = reqLen;
        mTag = mSpec;
        mSpec++;
        mWrBusy = 1;
      end else if (oldBusy && wrReady) begin
        mWrBusy = 0;
      end
      if (doCommit) mEvt = 1;
      else if (evtReady) mEvt = 0;
      if (doCommit) mCommit++;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      logic [255:0] expRec;
      check("R6", "reqReady", 256'(reqReady), 256'(!mWrBusy && !modelFull()));
      check("R4", "wrValid", 256'(wrValid), 256'(mWrBusy));
      if (mWrBusy) begin
        expRec = '0;
        expRec[31:16] = mIdx;
        expRec[47:32] = mLen;
        check("R3", "wrAddr", 256'(wrAddr), 256'(mAddr));
        check("R2", "wrData", wrData, expRec);
        check("R4", "wrTag", 256'(wrTag), 256'(mTag & 16'hFFFF));
      end
      check("R9", "evtValid", 256'(evtValid), 256'(mEvt));
      check("R9", "ackReady", 256'(ackReady), 256'(!mEvt || evtReady));
      check("R10", "headOut", 256'(headOut), 256'(mCommit & 16'hFFFF));
      if (mEvt) begin
        check("R7", "evtType", 256'(evtType), 256'h0);
        check("R7", "evtSource", 256'(evtSource), 256'h0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1", "wrValid", 256'(wrValid), 256'h0);
    check("R1", "evtValid", 256'(evtValid), 256'h0);
    check("R1", "headOut", 256'(headOut), 256'h0);
    check("R1", "reqReady", 256'(reqReady), 256'h1);
    tick();

    // single completion, maximum length
    reqValid = 1; reqIndex = 16'd5; reqLen = 16'd2048; wrReady = 1; evtReady = 1;
    tick();
    reqValid = 0;
    tick();
    ackValid = 1; ackTag = 16'd0;
    tick();
    ackValid = 0;
    #1;
    check("R7", "evtValid after ack", 256'(evtValid), 256'h1);
    check("R7", "headOut after ack", 256'(headOut), 256'h1);
    tick();

    // R8 acks with nothing outstanding
    ackValid = 1; ackTag = 16'd1;
    tick();
    ackTag = 16'd9;
    tick();
    ackValid = 0;
    #1;
    check("R8", "headOut idle ack", 256'(headOut), 256'h1);
    check("R8", "evtValid idle ack", 256'(evtValid), 256'h0);
    tick();

    // fill the four-entry ring, slots wrap to 0
    cfgTail = 16'd1;
    reqValid = 1;
    for (int i = 0; i < 10; i++) begin
      reqIndex = 16'(100 + i); reqLen = 16'(i * 64);
      tick();
    end
    reqValid = 0;
    #1;
    check("R6", "reqReady when full", 256'(reqReady), 256'h0);
    tick();

    // R8 mismatched tag while writes are outstanding
    ackValid = 1; ackTag = 16'd3;
    tick();
    ackValid = 0;
    #1;
    check("R8", "headOut wrong tag", 256'(headOut), 256'h1);
    check("R8", "evtValid wrong tag", 256'(evtValid), 256'h0);
    tick();

    // R9 event backpressure
    evtReady = 0;
    ackValid = 1; ackTag = 16'd1;
    tick();
    ackTag = 16'd2;
    tick(2);
    #1;
    check("R9", "headOut held", 256'(headOut), 256'h2);
    check("R9", "ackReady low", 256'(ackReady), 256'h0);
    evtReady = 1;
    tick();
    ackTag = 16'd3;
    tick();
    ackTag = 16'd4;
    tick();
    ackValid = 0;
    tick();
    #1;
    check("R10", "headOut drained", 256'(headOut), 256'h5);

    // R4/R5 write backpressure
    cfgTail = 16'd5; wrReady = 0;
    reqValid = 1; reqIndex = 16'hBEEF; reqLen = 16'd1;
    tick();
    reqIndex = 16'h1111;
    tick(3);
    #1;
    check("R5", "reqReady while held", 256'(reqReady), 256'h0);
    check("R4", "wrData held index", 256'(wrData[31:16]), 256'hBEEF);
    reqValid = 0; wrReady = 1;
    tick(2);

    // R6 wrapping distance: tail ahead of head reads as full
    cfgTail = 16'd7;
    tick();
    #1;
    check("R6", "tail ahead blocks", 256'(reqReady), 256'h0);
    cfgSizeLog = 5'd4; cfgTail = 16'd6;
    reqValid = 1; reqIndex = 16'd42; reqLen = 16'd77;
    tick();
    reqValid = 0;
    tick(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule